// File: doc/BRIEF.md
# Two-Core Doorbell Register Block

This block lets two processor cores signal each other through shared registers. Each core owns one 32-bit message word and one interrupt line. A core sends a message by writing bits into the other core's word through that word's set location. The receiving core sees its interrupt rise, reads its word, and then writes the bits it has handled to its clear location to remove them. The interrupt to a core stays high for as long as that core's word holds any nonzero bit.

Each core has its own simple register port, with an address, write data, a write strobe, a read strobe and read data. Both ports reach both words, so two accesses can land in the same cycle. If they do, all clears to a word are applied first and all sets after them. The address map repeats every 16 bytes, with one 16-byte group for each core. Within a group, offset 0x0 returns the current value, offset 0x4 is the set location and offset 0x8 is the clear location.

Top module: `xcore_doorbell`

## Requirements
- R1: After a synchronous active-low reset, both message words read 0 and both interrupt outputs are 0.
- R2: A write to a set location (0x04 for word 0, 0x14 for word 1) ORs the write data into that word.
- R3: A write to a clear location (0x08 for word 0, 0x18 for word 1) replaces the word with word & ~data. Writing all ones leaves the word at 0.
- R4: Interrupt output k is a registered copy of (word k != 0). It changes one clock edge after the word changes, and it falls one edge after the word becomes 0.
- R5: When a set and a clear reach the same word at the same edge, the new word is (word & ~clear) | set, so set bits win.
- R6: Port k serves core k (port 0 uses the lowest bits of each flat bus). Either port can set, clear and read either word. Sets from both ports to one word at the same edge are ORed together.
- R7: With the read strobe high, address 0x00 returns word 0 and address 0x10 returns word 1 combinationally. Reads of the set and clear locations return 0.
- R8: Addresses with either of bits 1:0 set, addresses at offset 0xC within a group, and addresses at or above 0x20 read 0 and ignore writes.
- R9: Read data is 0 while the read strobe is low, and reading never changes a word or an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | N_CORES*ADDR_W | Byte address for each port, port k at [k*ADDR_W +: ADDR_W] |
| bus_wdata | input | N_CORES*DATA_W | Write data for each port |
| bus_wr | input | N_CORES | Write strobe for each port |
| bus_rd | input | N_CORES | Read strobe for each port |
| bus_rdata | output | N_CORES*DATA_W | Combinational read data for each port |
| irq_out | output | N_CORES | Level interrupt to each core, bit k for word k |

## Verification
The bench seeds both words with known values, then writes an address-dependent pattern through each port to each of the 256 byte addresses. After each write it reads back both words and the address it wrote. This tells a correct decode apart from swapped locations, aliasing at 0xC or above 0x20, misaligned hits, and the OR and AND-NOT behaviour of set and clear. Directed cases then drive both ports in the same cycle, a set against a clear and a set against a set. Other directed cases measure the one-cycle lag of the interrupt on both the rising and the falling side, and show that reads with the strobe low, or repeated reads, change nothing.

// File: rtl/dbell_pkg.sv
// Package: shared register-field encoding and address geometry for the doorbell block.
// Assumes a 16-byte group per core, with the field selected by address bits 3:2.
package dbell_pkg;
    localparam int GROUP_LSB = 4;

    typedef enum logic [1:0] {
        FLD_VALUE = 2'd0,
        FLD_SET   = 2'd1,
        FLD_CLEAR = 2'd2,
        FLD_NONE  = 2'd3
    } dbell_fld_e;
endpackage

// File: rtl/dbell_port_decode.sv
// Module: decodes one core's register port into per-word set and clear masks and a read value.
// Assumes N_CORES is a power of two and ADDR_W is wider than the group index bits.
module dbell_port_decode
    import dbell_pkg::*;
#(
    parameter int N_CORES = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            wr,
    input  logic                            rd,
    input  logic [N_CORES-1:0][DATA_W-1:0]  words,
    output logic [N_CORES-1:0][DATA_W-1:0]  set_mask,
    output logic [N_CORES-1:0][DATA_W-1:0]  clr_mask,
    output logic [DATA_W-1:0]               rdata
);
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1;
    localparam int TOP_LSB = GROUP_LSB + IDX_W;

    dbell_fld_e       fld;
    logic [IDX_W-1:0] idx;
    logic             mapped;

    // Purpose: split the address into field and word index and qualify it as mapped.
    always_comb begin
        fld    = dbell_fld_e'(addr[3:2]);
        idx    = addr[GROUP_LSB +: IDX_W];
        mapped = (addr[1:0] == 2'b00) && ((addr >> TOP_LSB) == '0) && (fld != FLD_NONE);
    end

    for (genvar b = 0; b < N_CORES; b++) begin : g_box
        // Purpose: route write data to the set or clear mask of the addressed word.
        always_comb begin
            set_mask[b] = '0;
            clr_mask[b] = '0;
            if (wr && mapped && (idx == IDX_W'(b))) begin
                if (fld == FLD_SET)   set_mask[b] = wdata;
                if (fld == FLD_CLEAR) clr_mask[b] = wdata;
            end
        end
    end

    // Purpose: return the addressed word for a value-location read, otherwise zero.
    always_comb begin
        rdata = '0;
        if (rd && mapped && (fld == FLD_VALUE)) rdata = words[idx];
    end

    // R9: read data must stay quiet while the read strobe is low.
    p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> (rdata == '0));

    // R8: a misaligned access must never produce write masks.
    p_misaligned_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[1:0] != 2'b00) |-> ((set_mask == '0) && (clr_mask == '0) && (rdata == '0)));
endmodule

// File: rtl/dbell_box.sv
// Module: one message word with bitwise set/clear update and a registered nonzero interrupt.
// Assumes the set and clear masks are already merged over all ports; set bits win over clear bits.
module dbell_box #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] word,
    output logic              irq
);
    // Purpose: apply clears first, then sets, to the stored word.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= (word & ~clr_bits) | set_bits;
    end

    // Purpose: raise the interrupt one edge after the word holds any bit.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (word != '0);
    end

    // R2 / R5: every set bit is present after the edge, whatever the clear mask was.
    p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((word & $past(set_bits)) == $past(set_bits)));

    // R3: clear bits not also being set are gone after the edge.
    p_clear_removes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_bits & ~set_bits) != '0) |=> ((word & $past(clr_bits & ~set_bits)) == '0));

    // R9: with no masks the word holds its value.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_bits == '0) && (clr_bits == '0)) |=> $stable(word));

    // R4: the interrupt follows the word with one edge of lag.
    p_irq_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(word) == '0));
endmodule

// File: rtl/xcore_doorbell.sv
// Module: top of the two-core doorbell: one register port per core, one word and interrupt per core.
// Assumes single-cycle accesses; read data is combinational, writes take effect at the clock edge.
module xcore_doorbell #(
    parameter int N_CORES = 2,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_CORES*ADDR_W-1:0]   bus_addr,
    input  logic [N_CORES*DATA_W-1:0]   bus_wdata,
    input  logic [N_CORES-1:0]          bus_wr,
    input  logic [N_CORES-1:0]          bus_rd,
    output logic [N_CORES*DATA_W-1:0]   bus_rdata,
    output logic [N_CORES-1:0]          irq_out
);
    logic [N_CORES-1:0][DATA_W-1:0]                words;
    logic [N_CORES-1:0][N_CORES-1:0][DATA_W-1:0]   port_set;
    logic [N_CORES-1:0][N_CORES-1:0][DATA_W-1:0]   port_clr;
    logic [N_CORES-1:0][DATA_W-1:0]                set_all;
    logic [N_CORES-1:0][DATA_W-1:0]                clr_all;

    for (genvar p = 0; p < N_CORES; p++) begin : g_port
        dbell_port_decode #(
            .N_CORES (N_CORES),
            .DATA_W  (DATA_W),
            .ADDR_W  (ADDR_W)
        ) i_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr     (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata    (bus_wdata[p*DATA_W +: DATA_W]),
            .wr       (bus_wr[p]),
            .rd       (bus_rd[p]),
            .words    (words),
            .set_mask (port_set[p]),
            .clr_mask (port_clr[p]),
            .rdata    (bus_rdata[p*DATA_W +: DATA_W])
        );
    end

    // Purpose: merge the masks of all ports so concurrent accesses combine bitwise.
    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int p = 0; p < N_CORES; p++) begin
            for (int b = 0; b < N_CORES; b++) begin
                set_all[b] = set_all[b] | port_set[p][b];
                clr_all[b] = clr_all[b] | port_clr[p][b];
            end
        end
    end

    for (genvar b = 0; b < N_CORES; b++) begin : g_box
        dbell_box #(
            .DATA_W (DATA_W)
        ) i_box (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_all[b]),
            .clr_bits (clr_all[b]),
            .word     (words[b]),
            .irq      (irq_out[b])
        );

        // R4: a word holding bits for two edges must have its interrupt high.
        p_irq_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((words[b] != '0) && $stable(words[b])) |=> irq_out[b]);
    end

    // R1: right after reset is released, no interrupt is pending.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_out == '0));
endmodule

// File: tb/test_xcore_doorbell.sv
module test_xcore_doorbell;
    localparam int NC = 2;
    localparam int DW = 32;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC*AW-1:0]  bus_addr = '0;
    logic [NC*DW-1:0]  bus_wdata = '0;
    logic [NC-1:0]     bus_wr = '0;
    logic [NC-1:0]     bus_rd = '0;
    logic [NC*DW-1:0]  bus_rdata;
    logic [NC-1:0]     irq_out;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [NC];

    always #10 clk = ~clk;

    xcore_doorbell #(.N_CORES(NC), .DATA_W(DW), .ADDR_W(AW)) i_xcore_doorbell (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        if (a[1:0] != 2'b00 || a >= 8'h20 || a[3:2] != 2'd0) return '0;
        return model[a[4]];
    endfunction

    function automatic void model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (a[1:0] == 2'b00 && a < 8'h20) begin
            if (a[3:2] == 2'd1) model[a[4]] = model[a[4]] | d;
            if (a[3:2] == 2'd2) model[a[4]] = model[a[4]] & ~d;
        end
    endfunction

    // One write through port p; returns at the negedge after the capturing edge.
    task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr[p*AW +: AW] = a;
        bus_wdata[p*DW +: DW] = d;
        bus_wr[p] = 1'b1;
        @(negedge clk);
        bus_wr[p] = 1'b0;
        model_write(a, d);
    endtask

    // Same-edge writes from both ports; clears applied before sets in the model.
    task automatic wr2(input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                       input logic [AW-1:0] a1, input logic [DW-1:0] d1);
        @(negedge clk);
        bus_addr = {a1, a0};
        bus_wdata = {d1, d0};
        bus_wr = 2'b11;
        @(negedge clk);
        bus_wr = 2'b00;
        if (a0[3:2] == 2'd2) model_write(a0, d0);
        if (a1[3:2] == 2'd2) model_write(a1, d1);
        if (a0[3:2] == 2'd1) model_write(a0, d0);
        if (a1[3:2] == 2'd1) model_write(a1, d1);
    endtask

    task automatic rd(input int p, input logic [AW-1:0] a, output logic [DW-1:0] v);
        bus_addr[p*AW +: AW] = a;
        bus_rd[p] = 1'b1;
        #2;
        v = bus_rdata[p*DW +: DW];
        bus_rd[p] = 1'b0;
        #1;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] v;
        logic [DW-1:0] pat;
        model[0] = '0;
        model[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(0, 8'h00, v); chk("R1 word0 after reset", v, '0);
        rd(1, 8'h10, v); chk("R1 word1 after reset", v, '0);
        chk("R1 irq after reset", DW'(irq_out), '0);

        // R4: interrupt lags the word by one edge, both directions
        wr(1, 8'h04, 32'h0000_0001);
        chk("R4 irq0 one edge late on rise", DW'(irq_out[0]), '0);
        @(negedge clk);
        chk("R4 irq0 high", DW'(irq_out[0]), 32'd1);
        chk("R4 irq1 unaffected", DW'(irq_out[1]), '0);
        wr(0, 8'h08, 32'h0000_0001);
        chk("R4 irq0 still high one edge after clear", DW'(irq_out[0]), 32'd1);
        @(negedge clk);
        chk("R4 irq0 low", DW'(irq_out[0]), '0);

        // R3: all ones empties a word
        wr(0, 8'h14, 32'hDEAD_BEEF);
        wr(1, 8'h18, 32'hFFFF_FFFF);
        rd(1, 8'h10, v); chk("R3 all-ones clear empties word1", v, '0);
        @(negedge clk);
        chk("R3 irq1 low after empty", DW'(irq_out[1]), '0);

        // R9: read strobe low gives zero; reads have no side effect
        wr(0, 8'h04, 32'h1234_5678);
        @(negedge clk);
        bus_addr[AW-1:0] = 8'h00;
        #2; chk("R9 rdata zero without strobe", bus_rdata[DW-1:0], '0);
        rd(0, 8'h00, v); rd(1, 8'h00, v);
        @(negedge clk);
        rd(0, 8'h00, v); chk("R9 repeated read keeps word", v, 32'h1234_5678);
        chk("R9 irq kept after reads", DW'(irq_out[0]), 32'd1);

        // R5: set and clear to one word in the same edge, set wins
        wr2(8'h04, 32'h00FF_00F0, 8'h08, 32'h0FF0_FFFF);
        rd(0, 8'h00, v); chk("R5 same-edge set/clear", v, model[0]);
        chk("R5 model sanity", v, (32'h1234_5678 & ~32'h0FF0_FFFF) | 32'h00FF_00F0);

        // R6: sets from both ports to one word are ORed; cross-port access
        wr(0, 8'h18, 32'hFFFF_FFFF);
        wr2(8'h14, 32'hA000_0001, 8'h14, 32'h0500_0100);
        rd(0, 8'h10, v); chk("R6 concurrent sets ORed", v, 32'hA500_0101);
        rd(1, 8'h10, v); chk("R6 port1 reads word1", v, model[1]);

        // R2 R3 R7 R8: sweep every byte address through each port
        for (int p = 0; p < NC; p++) begin
            for (int a = 0; a < 256; a++) begin
                wr(p, 8'h08, 32'hFFFF_FFFF);
                wr(p, 8'h18, 32'hFFFF_FFFF);
                wr(p, 8'h04, 32'h0F0F_00F0);
                wr(p, 8'h14, 32'h3C00_0A55);
                pat = {a[7:0], 8'h5A, ~a[7:0], a[7:0]};
                wr(p, AW'(a), pat);
                rd(p, 8'h00, v); chk("R2/R3/R8 sweep word0", v, model[0]);
                rd(p, 8'h10, v); chk("R2/R3/R8 sweep word1", v, model[1]);
                rd(p, AW'(a), v); chk("R7/R8 sweep read map", v, exp_read(AW'(a)));
            end
        end

        disable watchdog;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule